// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block handles the modem handshake lines of a UART. On the receive side it compares the receive FIFO fill level with a selectable trigger level and drives the active-low request-to-send line (`rts_n`). The line is released at the trigger level. It is reasserted only once the FIFO has drained to the next lower trigger level, so the line does not chatter around a single threshold. When automatic mode is off, software drives the line directly through a control bit. While automatic mode is on, that control bit reads back the live line state, and writes to it are discarded.

On the transmit side the block stands between the transmit shift logic and its start decision. A start request from the shifter is granted only while the clear-to-send input (`cts_n`, active low) is asserted, once that input has passed a two-flop synchroniser. A frame that has already started is never cut short, because the block gates only the start of a character. With automatic clear-to-send off, every request is granted at once. The FIFO, the baud logic and the shifter are outside the block and connect through plain level, select and request/grant ports.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset `rts_n` is 1, the control register reads 0, and both automatic modes are off.
- R2: With automatic RTS off, `rts_n` equals the inverse of control bit 1 (1 = assert RTS), one cycle after the write.
- R3: With automatic RTS on (control bit 6 = 1), `rts_n` goes to 1 in the cycle after `fifo_level` reaches the trigger level. The trigger level is selected by `trig_sel` (0→1, 1→4, 2→8, 3→14 entries).
- R4: Once released, `rts_n` stays 1 while `fifo_level` is above the next lower level (0, 1, 4, 8 for `trig_sel` 0..3). It returns to 0 in the cycle after the level is at or below that value.
- R5: While automatic RTS is on, control bit 1 reads as the inverse of `rts_n`, and writes to bit 1 have no effect on the register or on `rts_n`.
- R6: With automatic CTS on (control bit 7 = 1), `tx_start_grant` is 1 only when `tx_start_request` is 1 and `cts_n` has been low for two clock edges. It is 0 from the second edge after `cts_n` rises.
- R7: With automatic CTS off, `tx_start_grant` equals `tx_start_request` whatever the value of `cts_n`.
- R8: Control bits 31:8, bit 0 and bits 5:2 always read 0 and ignore writes.
- R9: Turning automatic RTS off clears the hysteresis state. Turning it back on starts with RTS asserted unless the level is already at the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 32 | Control register write value |
| ctrl_rd_data | output | 32 | Control register read value |
| fifo_level | input | 5 | Receive FIFO occupancy |
| trig_sel | input | 2 | Trigger level select |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_start_request | input | 1 | Shifter asks to start a character |
| tx_start_grant | output | 1 | Start permitted |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The hardest state to reach is the hysteresis band. It needs automatic RTS on, a FIFO level that has passed the trigger and then drained to a value strictly between the lower level and the trigger. On top of that, the register write path has to be exercised while the line is held released. The stimulus walks `fifo_level` up to the trigger and back down one step above the lower level for every trigger select. It then disables and re-enables automatic mode at a level inside the band, which shows that the held state was cleared.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int REG_W        = 32;
    localparam int BIT_SW_RTS   = 1;
    localparam int BIT_AUTO_RTS = 6;
    localparam int BIT_AUTO_CTS = 7;

    typedef struct packed {
        logic auto_cts;
        logic auto_rts;
        logic sw_rts;
    } flow_cfg_t;

    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int lower_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 1;
            2'd2:    return 4;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/flow_ctrl_reg.sv
module flow_ctrl_reg
    import flow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hold_next,
    input  logic             rts_n,
    output flow_cfg_t        cfg,
    output logic [REG_W-1:0] rd_data
);
    flow_cfg_t cfg_q;
    logic      unused_wr;

    assign unused_wr = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (wr_en) begin
                cfg_q.auto_rts <= wr_data[BIT_AUTO_RTS];
                cfg_q.auto_cts <= wr_data[BIT_AUTO_CTS];
            end
            if (cfg_q.auto_rts)
                cfg_q.sw_rts <= ~hold_next;
            else if (wr_en)
                cfg_q.sw_rts <= wr_data[BIT_SW_RTS];
        end
    end

    always_comb begin
        rd_data               = '0;
        rd_data[BIT_AUTO_RTS] = cfg_q.auto_rts;
        rd_data[BIT_AUTO_CTS] = cfg_q.auto_cts;
        rd_data[BIT_SW_RTS]   = cfg_q.auto_rts ? ~rts_n : cfg_q.sw_rts;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/flow_rts_hyst.sv
module flow_rts_hyst
    import flow_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [1:0]       trig_sel,
    output logic             hold_q,
    output logic             hold_next
);
    int lvl;
    assign lvl = int'(fifo_level);

    always_comb begin
        hold_next = hold_q;
        if (!enable)
            hold_next = 1'b0;
        else if (!hold_q && lvl >= trig_level(trig_sel))
            hold_next = 1'b1;
        else if (hold_q && lvl <= lower_level(trig_sel))
            hold_next = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= hold_next;
    end
endmodule

// File: rtl/flow_cts_gate.sv
module flow_cts_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cts_n,
    input  logic req,
    output logic grant
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= cts_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b1;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign grant = req & (~enable | ~sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
    import flow_pkg::*;
#(
    parameter int LVL_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr_en,
    input  logic [REG_W-1:0] ctrl_wr_data,
    output logic [REG_W-1:0] ctrl_rd_data,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [1:0]       trig_sel,
    input  logic             cts_n,
    input  logic             tx_start_request,
    output logic             tx_start_grant,
    output logic             rts_n
);
    flow_cfg_t cfg;
    logic      hold_q;
    logic      hold_next;

    flow_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctrl_wr_en),
        .wr_data   (ctrl_wr_data),
        .hold_next (hold_next),
        .rts_n     (rts_n),
        .cfg       (cfg),
        .rd_data   (ctrl_rd_data)
    );

    flow_rts_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg.auto_rts),
        .fifo_level (fifo_level),
        .trig_sel   (trig_sel),
        .hold_q     (hold_q),
        .hold_next  (hold_next)
    );

    flow_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg.auto_cts),
        .cts_n  (cts_n),
        .req    (tx_start_request),
        .grant  (tx_start_grant)
    );

    assign rts_n = cfg.auto_rts ? hold_q : ~cfg.sw_rts;
endmodule

// File: rtl/flow_checker.sv
module flow_checker
    import flow_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] ctrl_rd_data,
    input logic [LVL_W-1:0] fifo_level,
    input logic [1:0]       trig_sel,
    input logic             tx_start_request,
    input logic             tx_start_grant,
    input logic             rts_n
);
    logic auto_r;
    logic auto_c;
    assign auto_r = ctrl_rd_data[BIT_AUTO_RTS];
    assign auto_c = ctrl_rd_data[BIT_AUTO_CTS];

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rts_n && ctrl_rd_data == '0));

    assert_trigger_release_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(auto_r) && auto_r && int'($past(fifo_level)) >= trig_level($past(trig_sel)))
        |-> rts_n);

    assert_hold_band_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(auto_r) && auto_r && $past(rts_n) &&
         int'($past(fifo_level)) > lower_level($past(trig_sel))) |-> rts_n);

    assert_mirror_R5: assert property (@(posedge clk) disable iff (rst)
        auto_r |-> (ctrl_rd_data[BIT_SW_RTS] == !rts_n));

    assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
        tx_start_grant |-> tx_start_request);

    assert_bypass_cts_R7: assert property (@(posedge clk) disable iff (rst)
        !auto_c |-> (tx_start_grant == tx_start_request));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd_data[REG_W-1:8] == '0 && ctrl_rd_data[5:2] == '0 && !ctrl_rd_data[0]));
endmodule

bind uart_flow_ctl flow_checker #(.LVL_W(LVL_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .ctrl_rd_data     (ctrl_rd_data),
    .fifo_level       (fifo_level),
    .trig_sel         (trig_sel),
    .tx_start_request (tx_start_request),
    .tx_start_grant   (tx_start_grant),
    .rts_n            (rts_n)
);

// File: tb/sim_uart_flow_ctl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr_en = 1'b0;
    logic [31:0] ctrl_wr_data = '0;
    logic [31:0] ctrl_rd_data;
    logic [4:0]  fifo_level = '0;
    logic [1:0]  trig_sel = '0;
    logic        cts_n = 1'b1;
    logic        tx_start_request = 1'b0;
    logic        tx_start_grant;
    logic        rts_n;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    uart_flow_ctl u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = d;
        @(posedge clk); #1;
        ctrl_wr_en = 1'b0;
    endtask

    task automatic set_level(input int v);
        @(negedge clk); fifo_level = 5'(v);
        step();
    endtask

    task automatic t_reset();
        check("R1 rts_n", 32'(rts_n), 32'd1);
        check("R1 ctrl", ctrl_rd_data, 32'd0);
    endtask

    task automatic t_sw_rts();
        wr(32'h2);
        check("R2 sw assert", 32'(rts_n), 32'd0);
        wr(32'h0);
        check("R2 sw release", 32'(rts_n), 32'd1);
    endtask

    task automatic t_levels();
        int trig[4] = '{1, 4, 8, 14};
        int low[4]  = '{0, 1, 4, 8};
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); trig_sel = 2'(s);
            set_level(0);
            wr(32'h40);
            check("R3 below trig", 32'(rts_n), 32'd0);
            set_level(trig[s] - 1);
            check("R3 one below", 32'(rts_n), 32'd0);
            set_level(trig[s]);
            check("R3 at trig", 32'(rts_n), 32'd1);
            set_level(trig[s] + 1);
            check("R3 overshoot", 32'(rts_n), 32'd1);
            set_level(low[s] + 1);
            check("R4 in band", 32'(rts_n), 32'd1);
            set_level(low[s]);
            check("R4 at lower", 32'(rts_n), 32'd0);
            wr(32'h0);
        end
    endtask

    task automatic t_mirror();
        @(negedge clk); trig_sel = 2'd1;
        set_level(0);
        wr(32'h40);
        check("R5 mirror low", 32'(ctrl_rd_data[1]), 32'd1);
        set_level(6);
        check("R5 mirror high", 32'(ctrl_rd_data[1]), 32'd0);
        wr(32'h42);
        check("R5 write ignored pin", 32'(rts_n), 32'd1);
        check("R5 write ignored bit", 32'(ctrl_rd_data[1]), 32'd0);
    endtask

    task automatic t_disable();
        wr(32'h0);
        check("R9 off keeps mirror", 32'(rts_n), 32'd1);
        wr(32'h2);
        check("R9 sw control back", 32'(rts_n), 32'd0);
        @(negedge clk); trig_sel = 2'd2;
        set_level(5);
        wr(32'h40);
        check("R9 hysteresis cleared", 32'(rts_n), 32'd0);
        wr(32'h0);
        set_level(0);
    endtask

    task automatic t_cts();
        wr(32'h80);
        @(negedge clk); cts_n = 1'b1; tx_start_request = 1'b1;
        step(); step();
        check("R6 blocked", 32'(tx_start_grant), 32'd0);
        @(negedge clk); cts_n = 1'b0;
        step();
        check("R6 sync stage", 32'(tx_start_grant), 32'd0);
        step();
        check("R6 granted", 32'(tx_start_grant), 32'd1);
        @(negedge clk); tx_start_request = 1'b0; #1;
        check("R6 no request", 32'(tx_start_grant), 32'd0);
        @(negedge clk); tx_start_request = 1'b1; cts_n = 1'b1;
        step();
        check("R6 release lag", 32'(tx_start_grant), 32'd1);
        step();
        check("R6 release", 32'(tx_start_grant), 32'd0);
    endtask

    task automatic t_cts_off();
        wr(32'h0);
        @(negedge clk); cts_n = 1'b1; tx_start_request = 1'b1; #1;
        check("R7 bypass", 32'(tx_start_grant), 32'd1);
        @(negedge clk); tx_start_request = 1'b0; #1;
        check("R7 bypass idle", 32'(tx_start_grant), 32'd0);
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FF3D);
        check("R8 reserved", ctrl_rd_data & 32'hFFFF_FF3D, 32'd0);
        wr(32'h0);
    endtask

    initial begin : watchdog
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        step();
        t_reset();
        t_sw_rts();
        t_levels();
        t_mirror();
        t_disable();
        t_cts();
        t_cts_off();
        t_reserved();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule